// File: doc/BRIEF.md
# Frame-Aligned Triggered Capture Gate

This block sits on the output of a vectorized channelizer that delivers several frequency bins per clock, each beat qualified by valid, start-of-frame and end-of-frame flags. It normally discards the stream. A single-cycle trigger pulse, produced when software writes a control register, arms it. Once armed, it waits for the next beat that opens a frame. It then forwards exactly one complete spectral frame downstream and marks the closing beat with a last flag.

With the default parameters a frame holds 512 bins carried four at a time, so a capture is 128 valid beats. Beat n carries bins 4n to 4n+3, and the final beat carries bin 511. The forwarded beats leave through a registered stage, one clock after they arrive. Status outputs report whether a capture is pending or running, give a one-cycle pulse when a frame has finished, and hold a sticky error if the source closes a frame early.

Top module: `spectral_frame_gate`

## Requirements
- R1: After reset, out_valid, out_last, busy, done and frame_err are all 0.
- R2: A trigger pulse while idle arms the gate, and busy reads 1 from the next cycle. While armed, beats without a valid start-of-frame are not forwarded, even when their end-of-frame flag is set.
- R3: Capture begins only on a beat with in_valid and in_sof both high. That beat is the first forwarded beat, and it appears on out_data with out_valid one clock after it is presented.
- R4: A capture forwards exactly FRAME_BINS/LANES valid beats (128 by default). They appear in arrival order with every lane's data unchanged.
- R5: During capture, cycles with in_valid low are neither forwarded nor counted toward the frame length, whatever the other input flags are.
- R6: out_last is asserted exactly once per completed capture, together with out_valid, on the 128th forwarded beat (the beat carrying bin 511).
- R7: done pulses high for exactly one cycle, in the same cycle that the final beat shows out_last. On the next cycle the gate is idle, with busy at 0.
- R8: A trigger pulse while armed, capturing or finishing is ignored. It neither restarts the capture nor leaves a second capture pending.
- R9: A valid end-of-frame before the 128th beat of a capture sets frame_err, and frame_err stays set until reset. The offending beat is not forwarded, no last or done is produced, and the gate returns to idle.
- R10: With no trigger, the gate forwards nothing, even across complete frames with start-of-frame present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Single-cycle capture request |
| in_valid | input | 1 | Input beat qualifier |
| in_sof | input | 1 | Input beat opens a frame |
| in_eof | input | 1 | Input beat closes a frame |
| in_data | input | LANES*LANE_W | Input bins, lane 0 in the low bits |
| out_valid | output | 1 | Forwarded beat strobe |
| out_last | output | 1 | Final beat of captured frame |
| out_data | output | LANES*LANE_W | Forwarded bins |
| busy | output | 1 | Armed or capturing |
| done | output | 1 | One-cycle frame-complete pulse |
| frame_err | output | 1 | Sticky early end-of-frame error |

## Verification
Some rules are checked by the assertions on every cycle. out_last only comes with out_valid, done only comes with the last beat, and the armed state holds until a start-of-frame beat. A capture never re-arms, the beat counter wraps only on its final beat, and the error flag is sticky. Other behaviour only the bench scenarios can show: the exact beat count under invalid gaps, in-order data integrity across lanes, a trigger that is ignored mid-capture, the truncated count after an early end-of-frame, and the absence of output without a trigger.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_ARMED   = 2'd1,
      ST_CAPTURE = 2'd2,
      ST_DONE    = 2'd3
   } gate_state_e;

endpackage

// File: rtl/sfc_beat_counter.sv
module sfc_beat_counter #(
   parameter int BEATS = 128
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       inc,
   output logic [$clog2(BEATS)-1:0]   count,
   output logic                       at_last
);
   localparam int CNT_W = $clog2(BEATS);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);

   if (BEATS < 2) begin : g_bad_beats
      $error("sfc_beat_counter: BEATS must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (inc)
         count <= (count == LAST_IDX) ? '0 : count + 1'b1;
   end

   assign at_last = (count == LAST_IDX);

   // R4: the final counted beat returns the counter to zero
   p_wrap_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && at_last) |=> (count == '0));

   // R5: no increment, no change
   p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(count));

endmodule

// File: rtl/sfc_ctrl_fsm.sv
module sfc_ctrl_fsm
   import sfc_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         trig,
   input  logic         in_valid,
   input  logic         in_sof,
   input  logic         in_eof,
   input  logic         at_last,
   output logic         cnt_clr,
   output logic         fwd,
   output logic         fwd_last,
   output gate_state_e  state,
   output logic         frame_err
);
   gate_state_e state_nxt;
   logic        err_set;

   always_comb begin
      state_nxt = state;
      cnt_clr   = 1'b0;
      fwd       = 1'b0;
      fwd_last  = 1'b0;
      err_set   = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (trig) begin
               state_nxt = ST_ARMED;
               cnt_clr   = 1'b1;
            end
         end
         ST_ARMED: begin
            if (in_valid && in_sof) begin
               if (in_eof) begin
                  err_set   = 1'b1;
                  state_nxt = ST_IDLE;
               end else begin
                  fwd       = 1'b1;
                  state_nxt = ST_CAPTURE;
               end
            end
         end
         ST_CAPTURE: begin
            if (in_valid) begin
               if (at_last) begin
                  fwd       = 1'b1;
                  fwd_last  = 1'b1;
                  state_nxt = ST_DONE;
               end else if (in_eof) begin
                  err_set   = 1'b1;
                  state_nxt = ST_IDLE;
               end else begin
                  fwd = 1'b1;
               end
            end
         end
         ST_DONE: state_nxt = ST_IDLE;
         default: state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         frame_err <= 1'b0;
      end else begin
         state <= state_nxt;
         if (err_set)
            frame_err <= 1'b1;
      end
   end

   // R2: armed state holds until a valid start-of-frame beat
   p_armed_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ARMED && !(in_valid && in_sof)) |=> (state == ST_ARMED));

   // R3: capture is entered only from a valid start-of-frame beat
   p_start_on_sof_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ARMED) ##1 (state == ST_CAPTURE) |-> $past(in_valid && in_sof));

   // R8: an active capture never returns to the armed state
   p_no_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CAPTURE || state == ST_DONE) |=> (state != ST_ARMED));

   // R9: error flag is sticky
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err);

   // R10: nothing forwarded from idle
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !fwd);

endmodule

// File: rtl/sfc_lane_stage.sv
module sfc_lane_stage #(
   parameter int W = 50
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (en)
         q <= d;
   end
endmodule

// File: rtl/spectral_frame_gate.sv
module spectral_frame_gate
   import sfc_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int LANE_W     = 50,
   parameter int FRAME_BINS = 512
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    trig,
   input  logic                    in_valid,
   input  logic                    in_sof,
   input  logic                    in_eof,
   input  logic [LANES*LANE_W-1:0] in_data,
   output logic                    out_valid,
   output logic                    out_last,
   output logic [LANES*LANE_W-1:0] out_data,
   output logic                    busy,
   output logic                    done,
   output logic                    frame_err
);
   localparam int BEATS = FRAME_BINS / LANES;
   localparam int CNT_W = $clog2(BEATS);

   if (LANES < 1) begin : g_bad_lanes
      $error("spectral_frame_gate: LANES must be positive");
   end
   if (FRAME_BINS % LANES != 0) begin : g_bad_split
      $error("spectral_frame_gate: FRAME_BINS must be a multiple of LANES");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("spectral_frame_gate: LANE_W must be positive");
   end

   gate_state_e      state;
   logic             cnt_clr;
   logic             fwd;
   logic             fwd_last;
   logic             at_last;
   logic [CNT_W-1:0] beat_cnt;

   sfc_ctrl_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (trig),
      .in_valid  (in_valid),
      .in_sof    (in_sof),
      .in_eof    (in_eof),
      .at_last   (at_last),
      .cnt_clr   (cnt_clr),
      .fwd       (fwd),
      .fwd_last  (fwd_last),
      .state     (state),
      .frame_err (frame_err)
   );

   sfc_beat_counter #(.BEATS(BEATS)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cnt_clr),
      .inc     (fwd),
      .count   (beat_cnt),
      .at_last (at_last)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      sfc_lane_stage #(.W(LANE_W)) u_stage (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (fwd),
         .d     (in_data[g*LANE_W +: LANE_W]),
         .q     (out_data[g*LANE_W +: LANE_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
      end else begin
         out_valid <= fwd;
         out_last  <= fwd_last;
      end
   end

   assign busy = (state == ST_ARMED) || (state == ST_CAPTURE);
   assign done = (state == ST_DONE);

   // R6: last marker always rides on a forwarded beat
   p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   // R7: done coincides with the final beat and lasts one cycle
   p_done_on_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (out_last && out_valid));
   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R4: counter position is unused outside capture bookkeeping
   p_cnt_zero_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ARMED) |-> (beat_cnt == '0));

endmodule

// File: tb/spectral_frame_gate_tb.sv
`timescale 1ns/1ps
module spectral_frame_gate_tb;
   localparam int LANES  = 4;
   localparam int LANE_W = 50;
   localparam int BINS   = 512;
   localparam int BEATS  = BINS / LANES;
   localparam int DW     = LANES * LANE_W;

   typedef struct packed {
      logic [7:0] pre;
      logic [7:0] gap;
      logic       retrig;
      logic [7:0] err_at;
      logic [7:0] tag;
   } scen_t;

   localparam int NSCN = 5;
   localparam scen_t SCN [NSCN] = '{
      '{pre: 8'd0, gap: 8'd0, retrig: 1'b0, err_at: 8'd0,  tag: 8'd1},
      '{pre: 8'd3, gap: 8'd0, retrig: 1'b0, err_at: 8'd0,  tag: 8'd2},
      '{pre: 8'd0, gap: 8'd5, retrig: 1'b0, err_at: 8'd0,  tag: 8'd3},
      '{pre: 8'd2, gap: 8'd3, retrig: 1'b1, err_at: 8'd0,  tag: 8'd4},
      '{pre: 8'd1, gap: 8'd0, retrig: 1'b0, err_at: 8'd40, tag: 8'd5}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_sof = 1'b0;
   logic          in_eof = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          out_valid, out_last, busy, done, frame_err;
   logic [DW-1:0] out_data;

   always #2.5 clk = ~clk;

   spectral_frame_gate #(.LANES(LANES), .LANE_W(LANE_W), .FRAME_BINS(BINS)) u_dut (
      .clk(clk), .rst_n(rst_n), .trig(trig), .in_valid(in_valid),
      .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
      .out_valid(out_valid), .out_last(out_last), .out_data(out_data),
      .busy(busy), .done(done), .frame_err(frame_err)
   );

   int  n_checks = 0;
   int  n_fail   = 0;
   int  rx_cnt, last_cnt, done_cnt;
   int  cur_tag;
   bit  finished = 1'b0;

   function automatic logic [DW-1:0] beat_word(int tag, int beat);
      logic [DW-1:0] w = '0;
      for (int l = 0; l < LANES; l++)
         w[l*LANE_W +: LANE_W] = LANE_W'({tag[7:0], beat[7:0], l[3:0]});
      return w;
   endfunction

   task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      if (out_valid) begin
         check(out_data == beat_word(cur_tag, rx_cnt), "R4 data order",
               out_data, beat_word(cur_tag, rx_cnt));
         rx_cnt++;
      end
      if (out_last) last_cnt++;
      if (done) begin
         done_cnt++;
         check(out_last == 1'b1, "R7 done with last", DW'(out_last), DW'(1));
      end
   endtask

   task automatic drive_idle();
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; trig = 1'b0;
      in_data  = '0;
   endtask

   task automatic clear_mon(int tag);
      cur_tag = tag; rx_cnt = 0; last_cnt = 0; done_cnt = 0;
   endtask

   // full frame offered without trigger: nothing may come out (R10, R8)
   task automatic untriggered_frame();
      for (int b = 0; b < 6; b++) begin
         in_valid = 1'b1; in_sof = (b == 0); in_eof = (b == 5);
         in_data = beat_word(8'hEE, b);
         tick();
      end
      drive_idle();
      tick();
   endtask

   task automatic run_frame(scen_t s, bit exp_err);
      int n_exp;
      clear_mon(s.tag);
      drive_idle();
      trig = 1'b1;
      tick();
      trig = 1'b0;
      check(busy == 1'b1, "R2 busy after trigger", DW'(busy), DW'(1));
      for (int p = 0; p < s.pre; p++) begin
         in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b1;
         in_data = beat_word(8'hAA, p);
         tick();
      end
      for (int b = 0; b < BEATS; b++) begin
         if (s.err_at != 0 && b > s.err_at) break;
         if (s.gap != 0 && b > 0 && (b % s.gap) == 0) begin
            in_valid = 1'b0; in_sof = 1'b1; in_eof = 1'b1;
            in_data = beat_word(8'hBB, b);
            tick();
         end
         trig     = (s.retrig && b == 10);
         in_valid = 1'b1;
         in_sof   = (b == 0);
         in_eof   = (b == BEATS - 1) || (s.err_at != 0 && b == s.err_at);
         in_data  = beat_word(s.tag, b);
         tick();
         trig = 1'b0;
         if (b == 0)
            check(rx_cnt == 1, "R3 first beat one clock later", DW'(rx_cnt), DW'(1));
      end
      drive_idle();
      repeat (3) tick();
      untriggered_frame();
      n_exp = (s.err_at != 0) ? int'(s.err_at) : BEATS;
      check(rx_cnt == n_exp, (s.err_at != 0) ? "R9 truncated count" : "R4 R5 beat count",
            DW'(rx_cnt), DW'(n_exp));
      check(last_cnt == ((s.err_at != 0) ? 0 : 1), "R6 last count",
            DW'(last_cnt), DW'((s.err_at != 0) ? 0 : 1));
      check(done_cnt == ((s.err_at != 0) ? 0 : 1), "R7 done count",
            DW'(done_cnt), DW'((s.err_at != 0) ? 0 : 1));
      check(frame_err == exp_err, "R9 error flag", DW'(frame_err), DW'(exp_err));
      check(busy == 1'b0, "R7 R8 idle after frame", DW'(busy), DW'(0));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      clear_mon(0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check({out_valid, out_last, busy, done, frame_err} == 5'b0, "R1 reset outputs",
            DW'({out_valid, out_last, busy, done, frame_err}), DW'(0));
      // R10 no trigger, no output
      clear_mon(8'hEE);
      untriggered_frame();
      check(rx_cnt == 0, "R10 no output without trigger", DW'(rx_cnt), DW'(0));

      for (int i = 0; i < NSCN; i++)
         run_frame(SCN[i], SCN[i].err_at != 0);

      // R9 sticky: a clean capture afterwards keeps the flag
      run_frame('{pre: 8'd0, gap: 8'd0, retrig: 1'b0, err_at: 8'd0, tag: 8'd9}, 1'b1);

      // R9 early end-of-frame on the opening beat
      clear_mon(8'h0C);
      trig = 1'b1; tick(); trig = 1'b0;
      in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_data = beat_word(8'h0C, 0);
      tick();
      drive_idle(); tick();
      check(rx_cnt == 0 && busy == 1'b0, "R9 sof+eof beat dropped",
            DW'({rx_cnt[7:0], busy}), DW'(0));

      // R1 reset clears the sticky error
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
      check(frame_err == 1'b0, "R1 R9 reset clears error", DW'(frame_err), DW'(0));

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule